// File: doc/BRIEF.md
# Codec register access sequencer

This block carries host reads and writes of an external audio codec's control registers across a serial link that is cut into frames. The host writes one 32-bit command word into a bus-mapped command register. The block keeps that command until the next frame boundary. It then drives the command-address slot and the command-data slot of one outgoing frame and sets their tag bits.

A write is finished once its frame has gone out. For a read, the block waits for the codec's reply in the incoming frame that follows. It takes the 16-bit value from the status-data slot and posts it in the readback view of the command register. Either kind of completion sets a status flag. When the mask allows it, that flag drives the interrupt output. The host takes the interrupt, reads the result from the command offset, and clears the flag by reading the status register.

The serialiser sits outside this block. It presents each slot as a parallel 20-bit value and marks frames with strobes that are already in the bus clock domain.

Top module: `codec_reg_seq`

## Requirements
- R1: After reset there is no pending command. `irq`, `tx_tag_addr` and `tx_tag_data` are 0, both outgoing slots are zero, and every register reads as zero.
- R2: A bus write to offset 0x10 with no command pending accepts a command. Bit 31 is the read flag (1 = read), bits 22:16 are the codec register address, and bits 15:0 are the write data. Bits 30:23 have no effect.
- R3: The `frame_sync` strobe after acceptance launches an accepted command. `tx_tag_addr` is 1 from the cycle after that strobe until the cycle of the next `frame_sync` strobe, inclusive, which is exactly one frame.
- R4: `tx_slot_addr` carries the read flag in bit 19, the address in bits 18:12 and zeros in bits 11:0. `tx_slot_data` carries the write data in bits 19:4 and zeros in bits 3:0. `tx_tag_data` is set only for write commands.
- R5: A write command completes on the `frame_sync` strobe that ends its frame. The done flag is 1 from the next cycle.
- R6: A read command completes on the first `rx_strobe` with `rx_tag` = 1 that comes after the end of its frame. Bits 19:4 of `rx_slot` go into readback bits 15:0. Strobes during the command frame, or with `rx_tag` = 0, are ignored.
- R7: A read of offset 0x10 returns the pending flag in bit 31, zeros in bits 30:16, and the last read result in bits 15:0.
- R8: A write to offset 0x10 while a command is pending is ignored: the outgoing slots and the sequence keep their values.
- R9: Offset 0x14 bit 0 is the interrupt enable. Offset 0x18 bit 0 reads the done flag. `irq` is the done flag ANDed with the enable.
- R10: A bus read of offset 0x18 clears the done flag. A completion in the same cycle wins, and the flag stays 1.
- R11: Reads of any other offset return zero. Writes to offset 0x18 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used for read-to-clear) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| frame_sync | input | 1 | One-cycle strobe, one cycle ahead of each outgoing frame |
| tx_tag_addr | output | 1 | Tag bit: command-address slot valid |
| tx_tag_data | output | 1 | Tag bit: command-data slot valid |
| tx_slot_addr | output | 20 | Outgoing command-address slot |
| tx_slot_data | output | 20 | Outgoing command-data slot |
| rx_strobe | input | 1 | One-cycle strobe: incoming status-data slot present |
| rx_tag | input | 1 | Incoming tag bit for the status-data slot |
| rx_slot | input | 20 | Incoming status-data slot |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest case to reach from the ports is a status read that lands in the same cycle as a completion. The bench brings it about by holding the read strobe on the status offset on every cycle while a write command is in flight, so one read is certain to meet the completing `frame_sync`.

A read reply also has to be rejected for several frames in a row. The bench keeps `rx_tag` low for a few frames before it releases the reply. It also checks that strobes inside the command frame are ignored.

A behavioural model compares every output on every cycle, including commands written while one is pending and words with bits 30:23 set.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;
  localparam int SLOT_W   = 20;
  localparam int DATA_W   = 16;
  localparam int CADDR_W  = 7;
  localparam int WORD_W   = 32;
  localparam int DATA_LSB = SLOT_W - DATA_W;            // 4
  localparam int ADDR_LSB = SLOT_W - 1 - CADDR_W;       // 12

  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_SEND, PH_RESP} phase_t;

  typedef struct packed {
    logic               is_read;
    logic [CADDR_W-1:0] addr;
    logic [DATA_W-1:0]  data;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [WORD_W-1:0] w);
    cmd_t c;
    c.is_read = w[WORD_W-1];
    c.addr    = w[DATA_W+CADDR_W-1:DATA_W];
    c.data    = w[DATA_W-1:0];
    return c;
  endfunction

  function automatic logic [SLOT_W-1:0] addr_slot(input cmd_t c);
    return {c.is_read, c.addr, {ADDR_LSB{1'b0}}};
  endfunction

  function automatic logic [SLOT_W-1:0] data_slot(input cmd_t c);
    return {c.data, {DATA_LSB{1'b0}}};
  endfunction

  function automatic logic [DATA_W-1:0] reply_data(input logic [SLOT_W-1:0] s);
    return s[SLOT_W-1:DATA_LSB];
  endfunction

  function automatic logic [WORD_W-1:0] pack_readback(input logic busy,
                                                      input logic [DATA_W-1:0] d);
    return {busy, {(WORD_W-1-DATA_W){1'b0}}, d};
  endfunction
endpackage

// File: rtl/codec_cmd_fsm.sv
module codec_cmd_fsm
  import codec_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr_req,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              frame_sync,
  input  logic              rx_strobe,
  input  logic              rx_tag,
  input  logic [SLOT_W-1:0] rx_slot,
  output logic              busy,
  output logic              cmd_done,
  output logic              tx_tag_addr,
  output logic              tx_tag_data,
  output logic [SLOT_W-1:0] tx_slot_addr,
  output logic [SLOT_W-1:0] tx_slot_data,
  output logic [DATA_W-1:0] rd_result
);
  phase_t phase;
  cmd_t   cmd_q;

  logic write_finished, read_finished;
  assign write_finished = (phase == PH_SEND) && frame_sync && !cmd_q.is_read;
  assign read_finished  = (phase == PH_RESP) && rx_strobe && rx_tag;
  assign cmd_done       = write_finished || read_finished;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cmd_q     <= '0;
      rd_result <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (cmd_wr_req) begin
          cmd_q <= decode_cmd(cmd_word);
          phase <= PH_WAIT;
        end
        PH_WAIT: if (frame_sync) phase <= PH_SEND;
        PH_SEND: if (frame_sync) phase <= cmd_q.is_read ? PH_RESP : PH_IDLE;
        PH_RESP: if (read_finished) begin
          rd_result <= reply_data(rx_slot);
          phase     <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy         = (phase != PH_IDLE);
  assign tx_tag_addr  = (phase == PH_SEND);
  assign tx_tag_data  = (phase == PH_SEND) && !cmd_q.is_read;
  assign tx_slot_addr = addr_slot(cmd_q);
  assign tx_slot_data = data_slot(cmd_q);

  AST_TAG_RISE_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_tag_addr) |-> $past(frame_sync)); // R3
  AST_TAG_FALL_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_tag_addr) |-> $past(frame_sync)); // R3
  AST_DATA_TAG_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tag_data |-> (tx_tag_addr && !tx_slot_addr[SLOT_W-1])); // R4
  AST_BUSY_KEEPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_req && busy) |=> ($stable(tx_slot_addr) && $stable(tx_slot_data))); // R8
  AST_IDLE_NO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_tag_addr); // R3
endmodule

// File: rtl/codec_irq_regs.sv
module codec_irq_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic mask_wr,
  input  logic mask_wbit,
  input  logic stat_rd,
  input  logic cmd_done,
  output logic irq_en,
  output logic done_flag,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en    <= 1'b0;
      done_flag <= 1'b0;
    end else begin
      if (mask_wr) irq_en <= mask_wbit;
      if (cmd_done)     done_flag <= 1'b1;
      else if (stat_rd) done_flag <= 1'b0;
    end
  end

  assign irq = done_flag && irq_en;

  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> done_flag); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !cmd_done) |=> !done_flag); // R10
  AST_DONE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(cmd_done)); // R9
endmodule

// File: rtl/codec_reg_seq.sv
module codec_reg_seq
  import codec_seq_pkg::*;
#(
  parameter int          BUS_AW   = 8,
  parameter logic [7:0]  OFF_CMD  = 8'h10,
  parameter logic [7:0]  OFF_MASK = 8'h14,
  parameter logic [7:0]  OFF_STAT = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BUS_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              frame_sync,
  output logic              tx_tag_addr,
  output logic              tx_tag_data,
  output logic [19:0]       tx_slot_addr,
  output logic [19:0]       tx_slot_data,
  input  logic              rx_strobe,
  input  logic              rx_tag,
  input  logic [19:0]       rx_slot,
  output logic              irq
);
  logic sel_cmd, sel_mask, sel_stat;
  logic cmd_wr_req, mask_wr, stat_rd;
  logic busy, cmd_done, irq_en, done_flag;
  logic [DATA_W-1:0] rd_result;

  assign sel_cmd    = (reg_addr == BUS_AW'(OFF_CMD));
  assign sel_mask   = (reg_addr == BUS_AW'(OFF_MASK));
  assign sel_stat   = (reg_addr == BUS_AW'(OFF_STAT));
  assign cmd_wr_req = reg_wr && sel_cmd;
  assign mask_wr    = reg_wr && sel_mask;
  assign stat_rd    = reg_rd && sel_stat;

  codec_cmd_fsm u_fsm (
    .clk, .rst_n, .cmd_wr_req, .cmd_word(reg_wdata), .frame_sync,
    .rx_strobe, .rx_tag, .rx_slot, .busy, .cmd_done,
    .tx_tag_addr, .tx_tag_data, .tx_slot_addr, .tx_slot_data, .rd_result
  );

  codec_irq_regs u_irq (
    .clk, .rst_n, .mask_wr, .mask_wbit(reg_wdata[0]), .stat_rd,
    .cmd_done, .irq_en, .done_flag, .irq
  );

  always_comb begin
    reg_rdata = '0;
    if (sel_cmd)       reg_rdata = pack_readback(busy, rd_result);
    else if (sel_mask) reg_rdata = {31'b0, irq_en};
    else if (sel_stat) reg_rdata = {31'b0, done_flag};
  end

  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sel_cmd |-> (reg_rdata[30:16] == '0)); // R7
endmodule

// File: tb/codec_reg_seq_tb.sv
module codec_reg_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 16;

  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        frame_sync = 0, rx_strobe = 0, rx_tag = 0;
  logic [19:0] rx_slot = 0;
  logic        tx_tag_addr, tx_tag_data, irq;
  logic [19:0] tx_slot_addr, tx_slot_data;

  codec_reg_seq u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic tag_en = 0;

  // behavioural model state
  int m_phase = 0;            // 0 idle, 1 waiting, 2 sending, 3 awaiting reply
  int m_isrd = 0, m_addr = 0, m_wdata = 0, m_result = 0, m_done = 0, m_en = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_sim();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // reference model, updated on each rising edge from the inputs present then
  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_isrd = 0; m_addr = 0; m_wdata = 0; m_result = 0; m_done = 0; m_en = 0;
    end else begin
      int fin;
      bit clr;
      fin = 0;
      clr = reg_rd && reg_addr == 8'h18;
      if (m_phase == 0) begin
        if (reg_wr && reg_addr == 8'h10) begin
          m_isrd  = (reg_wdata >> 31) & 1;
          m_addr  = (reg_wdata >> 16) % 128;
          m_wdata = reg_wdata % 65536;
          m_phase = 1;
        end
      end else if (m_phase == 1) begin
        if (frame_sync) m_phase = 2;
      end else if (m_phase == 2) begin
        if (frame_sync) begin
          if (m_isrd) m_phase = 3;
          else begin m_phase = 0; fin = 1; end
        end
      end else begin
        if (rx_strobe && rx_tag) begin
          m_result = (rx_slot / 16) % 65536;
          m_phase = 0; fin = 1;
        end
      end
      if (reg_wr && reg_addr == 8'h14) m_en = reg_wdata % 2;
      if (fin) m_done = 1;
      else if (clr) m_done = 0;
    end
  end

  function automatic longint exp_rdata();
    if (reg_addr == 8'h10) return (m_phase != 0 ? 64'h8000_0000 : 0) + m_result;
    if (reg_addr == 8'h14) return m_en;
    if (reg_addr == 8'h18) return m_done;
    return 0;
  endfunction

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    longint ea, ed;
    ea = m_isrd * (1 << 19) + m_addr * (1 << 12);
    ed = m_wdata * 16;
    chk(tx_slot_addr == 20'(ea), "R4 slot_addr", tx_slot_addr, ea);
    chk(tx_slot_data == 20'(ed), "R4 slot_data", tx_slot_data, ed);
    chk(tx_tag_addr == (m_phase == 2), "R3 tag_addr", tx_tag_addr, m_phase == 2);
    chk(tx_tag_data == (m_phase == 2 && !m_isrd), "R4 tag_data", tx_tag_data, m_phase == 2 && !m_isrd);
    chk(irq == (m_done && m_en), "R9 irq", irq, m_done && m_en);
    chk(reg_rdata == 32'(exp_rdata()), "R7 rdata", reg_rdata, exp_rdata());
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      finish_sim();
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  // frame generator: sync every FRAME cycles, reply strobe mid-frame
  initial begin
    int fc;
    fc = 0;
    @(posedge rst_n); #1;
    forever begin
      fc++;
      frame_sync = (fc % FRAME == 0);
      rx_strobe  = (fc % FRAME == 8);
      rx_tag     = tag_en;
      if (fc % FRAME == 8) rx_slot = 20'($urandom);
      tick();
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick(); reg_wr = 0;
  endtask
  task automatic bus_rd(input logic [7:0] a);
    reg_rd = 1; reg_addr = a; tick(); reg_rd = 0;
  endtask
  task automatic wait_idle();
    while (m_phase != 0) tick();
  endtask

  initial begin
    repeat (3) tick();
    // R1 reset state
    reg_addr = 8'h10; #1;
    chk(reg_rdata == 0 && irq == 0 && tx_tag_addr == 0 && tx_slot_addr == 0, "R1 reset", reg_rdata, 0);
    rst_n = 1; tick();

    bus_wr(8'h14, 1);                                   // R9 enable
    reg_addr = 8'h14; #1; chk(reg_rdata == 1, "R9 mask readback", reg_rdata, 1);

    bus_wr(8'h10, 32'h0015_ABCD);                       // R2 write command
    while (m_phase != 2) tick();
    tick(); #1;
    chk(tx_tag_addr && tx_tag_data, "R3 tags in frame", {tx_tag_addr, tx_tag_data}, 3);
    chk(tx_slot_addr == 20'h15000, "R4 addr slot", tx_slot_addr, 20'h15000);
    chk(tx_slot_data == 20'hABCD0, "R4 data slot", tx_slot_data, 20'hABCD0);
    wait_idle(); tick(); #1;
    chk(irq == 1, "R5 write done irq", irq, 1);
    bus_rd(8'h18); #1;
    chk(irq == 0, "R10 read clears", irq, 0);

    // R6/R2 read command with bits 30:23 set, reply withheld
    tag_en = 0;
    bus_wr(8'h10, 32'hFFAA_1234);
    repeat (3 * FRAME) tick();
    reg_addr = 8'h10; #1;
    chk(reg_rdata[31] == 1, "R7 busy bit", reg_rdata[31], 1);
    chk(tx_slot_addr == 20'hAA000, "R2 addr ignores 30:23", tx_slot_addr, 20'hAA000);
    bus_wr(8'h10, 32'h0003_5555);                       // R8 ignored while pending
    #1; chk(tx_slot_addr == 20'hAA000, "R8 cmd kept", tx_slot_addr, 20'hAA000);
    tag_en = 1;
    wait_idle(); reg_addr = 8'h10; #1;
    chk(reg_rdata[31:16] == 0, "R6 result upper zero", reg_rdata[31:16], 0);
    chk(irq == 1, "R6 read done irq", irq, 1);
    bus_rd(8'h18);

    // R9 masked completion
    bus_wr(8'h14, 0);
    bus_wr(8'h10, 32'h0001_0001);
    wait_idle(); tick(); reg_addr = 8'h18; #1;
    chk(reg_rdata == 1 && irq == 0, "R9 masked", {reg_rdata[0], irq}, 2);

    // R11 other offsets and ignored status write
    bus_wr(8'h18, 0); reg_addr = 8'h18; #1;
    chk(reg_rdata == 1, "R11 status write ignored", reg_rdata, 1);
    reg_addr = 8'h1C; #1; chk(reg_rdata == 0, "R11 unmapped", reg_rdata, 0);
    bus_rd(8'h18);

    // R10 status read held through a completion
    bus_wr(8'h14, 1);
    bus_wr(8'h10, 32'h0022_0F0F);
    reg_rd = 1; reg_addr = 8'h18;
    while (m_phase != 0) tick();
    #1; chk(reg_rdata == 1, "R10 completion beats clear", reg_rdata, 1);
    tick(); reg_rd = 0; #1;
    chk(irq == 0, "R10 cleared after", irq, 0);

    // mixed commands
    for (int i = 0; i < 20; i++) begin
      bus_wr(8'h10, $urandom);
      if (i % 3 == 0) bus_wr(8'h10, $urandom);
      wait_idle();
      bus_rd(8'h18);
    end
    repeat (5) tick();
    finish_sim();
  end
endmodule